// File: doc/BRIEF.md
# Windowless Watchdog Timer With Hardware And Halt Options

This block guards a small microcontroller against a runaway program. Software controls it through one 8-bit register. Bit 7 is the run flag. Bits 6..0 are a 7-bit down-counter. A prescaler runs freely, divides the CPU clock and gives the counter one decrement step per division period. When counter bit 6 drops from 1 to 0 while the watchdog runs, the block raises a one-clock reset request for the chip's reset sequencer. Software avoids this by reloading the register, normally with a value in the range C0h..FFh. Bits 5..0 of that value then set how many steps remain before the reset.

Two static option inputs tune the block. The first keeps the watchdog permanently running, so the run flag has no effect. The second lets the CPU halt while the watchdog runs. Without it, a halt request from an active watchdog becomes a reset. The state machine `wdt_fsm` holds three states. `WD_OFF` is the disabled state after reset. `WD_RUN` means armed and counting. `WD_FIRE` means a reset request is being issued. Its transitions:
- `WD_OFF`→`WD_RUN` when a write sets the run flag, or when the hardware option is set.
- `WD_OFF`→`WD_FIRE` when the write that sets the run flag also clears bit 6.
- `WD_RUN`→`WD_FIRE` on a trip. A trip is a counter fall, a write with bit 6 clear, or a forbidden halt.
- `WD_FIRE`→`WD_RUN` when no new trip occurs.
- `WD_FIRE`→`WD_FIRE` when another trip falls in the same cycle.

Top module: `wdt_ctrl`

## Requirements
- R1: After reset with the hardware option low, the register reads 8'h7F (run flag 0, counter 7'h7F), and `rst_req` is low.
- R2: A write with bit 7 set makes the watchdog active. Later writes with bit 7 clear leave read bit 7 at 1. Only `rst_n` clears it.
- R3: While active, the counter (read bits 6..0) decreases by one on each prescaler tick and holds between ticks. While inactive, it holds.
- R4: The prescaler runs freely with period `PRESC_DIV`, and a write does not restart it. After a write of C0h, `rst_req` rises between 1 and `PRESC_DIV` cycles after the write edge. After a write of FFh, it rises between 63·`PRESC_DIV`+1 and 64·`PRESC_DIV` cycles after the write edge.
- R5: When counter bit 6 falls from 1 to 0 on a tick while active, `rst_req` is high for exactly the one cycle after that edge.
- R6: A write with bit 6 clear, made while active or together with bit 7 set, raises `rst_req` in the cycle right after the write edge.
- R7: A write loads bits 6..0 into the counter, and this load wins over a tick in the same cycle (no decrement).
- R8: With `opt_hw_on` high, the watchdog is active from reset. Read bit 7 is 1 and the counter decrements, whatever value is written to bit 7.
- R9: A `halt_req` while active with `opt_halt_ok` low drives `halt_ok` low and raises `rst_req` in the next cycle.
- R10: A `halt_req` with `opt_halt_ok` high, or while inactive, drives `halt_ok` high in the same cycle and raises no reset.
- R11: While inactive, the counter does not move and no reset request appears, even after a write with bit 6 clear and bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_hw_on | input | 1 | Static option: watchdog always active |
| opt_halt_ok | input | 1 | Static option: halt allowed while active |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Write data: bit 7 run flag, bits 6..0 counter |
| halt_req | input | 1 | CPU requests to halt |
| reg_rdata | output | 8 | Read data: bit 7 active, bits 6..0 counter |
| halt_ok | output | 1 | Halt may proceed (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can meet in the same cycle: a software reload and a prescaler tick. The load must win and the decrement must be lost. The bench tracks the prescaler phase in its own model and issues a write exactly when the model says the tick is due, then judges the read-back counter against the written value. A second collision is a halt request arriving while the watchdog is armed. Its `halt_ok` and the following reset pulse are compared on every clock against the behavioural model, with both values of the halt option.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W = 7;
    localparam int TOP_BIT = CNT_W - 1;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef logic [CNT_W-1:0] wd_cnt_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // free-running divider: never cleared by register traffic
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  wd_cnt_t load_val,
    input  logic    step,
    output wd_cnt_t q,
    output wd_cnt_t q_next
);
    wd_cnt_t cnt_q;

    // load has priority over a step in the same cycle
    always_comb begin
        if (load)
            q_next = load_val;
        else if (step)
            q_next = cnt_q - 1'b1;
        else
            q_next = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else
            cnt_q <= q_next;
    end

    assign q = cnt_q;

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic trip,
    output logic armed,
    output logic fire
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (trip)
                    state_d = WD_FIRE;
                else if (arm)
                    state_d = WD_RUN;
            end
            WD_RUN: begin
                if (trip)
                    state_d = WD_FIRE;
            end
            WD_FIRE: begin
                state_d = trip ? WD_FIRE : WD_RUN;
            end
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        armed = (state_q != WD_OFF);
        fire  = (state_q == WD_FIRE);
    end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int PRESC_DIV = 16384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       opt_hw_on,
    input  logic       opt_halt_ok,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       halt_req,
    output logic [7:0] reg_rdata,
    output logic       halt_ok,
    output logic       rst_req
);
    logic    tick;
    logic    armed;
    logic    active_now;
    logic    active_next;
    logic    set_run;
    logic    fall;
    logic    wr_trip;
    logic    halt_trip;
    logic    trip;
    wd_cnt_t cnt_q;
    wd_cnt_t cnt_d;

    wdt_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign active_now  = opt_hw_on | armed;
    assign set_run     = reg_wr & reg_wdata[7];
    assign active_next = active_now | set_run;

    wdt_down_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr),
        .load_val (reg_wdata[CNT_W-1:0]),
        .step     (active_now & tick),
        .q        (cnt_q),
        .q_next   (cnt_d)
    );

    assign fall      = cnt_q[TOP_BIT] & ~cnt_d[TOP_BIT];
    assign wr_trip   = reg_wr & ~reg_wdata[TOP_BIT];
    assign halt_trip = halt_req & active_now & ~opt_halt_ok;
    assign trip      = (active_next & (fall | wr_trip)) | halt_trip;

    wdt_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (set_run | opt_hw_on),
        .trip  (trip),
        .armed (armed),
        .fire  (rst_req)
    );

    assign reg_rdata = {active_now, cnt_q};
    assign halt_ok   = halt_req & ~(active_now & ~opt_halt_ok);

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       opt_hw_on,
    input logic       opt_halt_ok,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       halt_req,
    input logic [7:0] reg_rdata,
    input logic       halt_ok,
    input logic       rst_req
);
    // R2
    sticky_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |=> reg_rdata[7]);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[7] && !(reg_wr && reg_wdata[7])) |=> !rst_req);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[7] && !reg_wr) |=> $stable(reg_rdata[6:0]));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !reg_wr) |=>
            (reg_rdata[6:0] == $past(reg_rdata[6:0]) ||
             reg_rdata[6:0] == $past(reg_rdata[6:0]) - 7'd1));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[6:0] == $past(reg_wdata[6:0]));

    // R9
    halt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && reg_rdata[7] && !opt_halt_ok) |=> rst_req);

    // R10
    halt_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && opt_halt_ok) |-> halt_ok);

    // R8
    hw_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_hw_on |-> reg_rdata[7]);

endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opt_hw_on   (opt_hw_on),
    .opt_halt_ok (opt_halt_ok),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .halt_req    (halt_req),
    .reg_rdata   (reg_rdata),
    .halt_ok     (halt_ok),
    .rst_req     (rst_req)
);

// File: tb/wdt_ctrl_test.sv
module wdt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_hw_on = 1'b0;
    logic       opt_halt_ok = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       halt_req = 1'b0;
    logic [7:0] reg_rdata;
    logic       halt_ok;
    logic       rst_req;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";

    // behavioural reference state
    int m_pre = 0;
    int m_cnt = 127;
    bit m_en = 0;
    bit m_rst = 0;

    wdt_ctrl #(.PRESC_DIV(DIV)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .opt_hw_on   (opt_hw_on),
        .opt_halt_ok (opt_halt_ok),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .halt_req    (halt_req),
        .reg_rdata   (reg_rdata),
        .halt_ok     (halt_ok),
        .rst_req     (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 127; m_en = 0; m_rst = 0;
        end else begin
            bit act, act_n, tk, trip;
            int nc;
            tk    = (m_pre == DIV - 1);
            act   = opt_hw_on || m_en;
            act_n = act || (reg_wr && reg_wdata[7]);
            if (reg_wr) nc = int'(reg_wdata[6:0]);
            else if (act && tk) nc = (m_cnt + 127) % 128;
            else nc = m_cnt;
            trip = (act_n && ((m_cnt >= 64 && nc < 64) || (reg_wr && !reg_wdata[6])))
                   || (halt_req && act && !opt_halt_ok);
            m_rst = trip;
            m_en  = m_en || (reg_wr && reg_wdata[7]);
            m_pre = (m_pre + 1) % DIV;
            m_cnt = nc;
        end
    end

    task automatic check(input string r, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit act;
            act = opt_hw_on || m_en;
            check(tag, int'(reg_rdata), int'({act, 7'(m_cnt)}), "rdata");
            check(tag, int'(rst_req), int'(m_rst), "rst_req");
            check(tag, int'(halt_ok), int'(halt_req && !(act && !opt_halt_ok)), "halt_ok");
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic do_reset(input bit hw, input bit hok);
        @(posedge clk); #2;
        rst_n = 1'b0; opt_hw_on = hw; opt_halt_ok = hok;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic measure(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(negedge clk); n++;
            if (rst_req) break;
        end
    endtask

    initial begin
        int n;
        do_reset(0, 0);
        tag = "R1";
        @(negedge clk);
        check("R1", int'(reg_rdata), 8'h7F, "reset rdata");
        check("R1", int'(rst_req), 0, "reset rst_req");
        idle(2);

        // inactive halt allowed
        tag = "R10";
        halt_req = 1'b1;
        @(negedge clk);
        check("R10", int'(halt_ok), 1, "idle halt_ok");
        #1 halt_req = 1'b0;
        idle(1);

        // disabled: write with bit 6 clear gives nothing
        tag = "R11";
        do_write(8'h3F);
        idle(3 * DIV);
        @(negedge clk);
        check("R11", int'(reg_rdata), 8'h3F, "counter frozen");
        check("R11", int'(rst_req), 0, "no reset while idle");

        // arm, then try to clear the run flag
        tag = "R2";
        do_write(8'hC5);
        do_write(8'h45);
        @(negedge clk);
        check("R2", int'(reg_rdata[7]), 1, "run flag sticky");
        tag = "R3";
        idle(4 * DIV);

        // timing windows
        tag = "R4";
        do_write(8'hC0);
        measure(DIV + 4, n);
        check("R4", int'(n >= 2 && n <= DIV + 1), 1, "C0 latency window");
        @(negedge clk);
        check("R5", int'(rst_req), 0, "pulse width one");
        do_write(8'hFF);
        measure(64 * DIV + 4, n);
        check("R4", int'(n >= 63 * DIV + 2 && n <= 64 * DIV + 1), 1, "FF latency window");
        idle(3);

        // write collides with a tick
        tag = "R7";
        while (m_pre != DIV - 1) idle(1);
        reg_wr = 1'b1; reg_wdata = 8'hD0;
        @(posedge clk); #2 reg_wr = 1'b0;
        @(negedge clk);
        check("R7", int'(reg_rdata[6:0]), 8'h50, "load beats tick");

        // immediate software reset
        tag = "R6";
        do_write(8'hA0);
        @(negedge clk);
        check("R6", int'(rst_req), 1, "software reset");
        do_write(8'hF0);

        // forbidden halt
        tag = "R9";
        halt_req = 1'b1;
        @(negedge clk);
        check("R9", int'(halt_ok), 0, "halt refused");
        @(posedge clk); #2 halt_req = 1'b0;
        @(negedge clk);
        check("R9", int'(rst_req), 1, "halt reset");

        // halt option
        do_reset(0, 1);
        tag = "R10";
        do_write(8'hF0);
        halt_req = 1'b1;
        @(negedge clk);
        check("R10", int'(halt_ok), 1, "halt allowed");
        @(posedge clk); #2 halt_req = 1'b0;
        @(negedge clk);
        check("R10", int'(rst_req), 0, "no halt reset");

        // hardware always-on
        do_reset(1, 0);
        tag = "R8";
        @(negedge clk);
        check("R8", int'(reg_rdata[7]), 1, "active from reset");
        do_write(8'h7F);
        idle(2 * DIV + 1);
        @(negedge clk);
        check("R8", int'(reg_rdata[7]), 1, "flag ignored");
        check("R8", int'(reg_rdata[6:0] < 7'h7F), 1, "counts in hw mode");
        idle(2);
        summary();
    end

endmodule